// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block is a synthesizable model of a single-port synchronous static RAM. It stores words of 18 bits split into two 9-bit byte lanes, and a parameter sets its depth. Address, write data, chip selects, strobes and write controls are all captured in an input register on the rising clock edge. Read data passes through a second, output register, so a read result appears one clock after the access cycle.

An access sequence, called a burst, starts when either of two address strobes is asserted. The processor-side strobe is honoured only while the primary chip select is active. The controller-side strobe is always honoured; it selects the device only when all three chip selects are active, and otherwise deselects it. After the start cycle, an advance input either steps a 2-bit counter held in the two low address bits or holds the current word. The counter wraps within a group of four words and the upper address bits do not change.

The write controls give per-lane writes. These pass through a byte-write master enable, and a global write overrides them to write the whole word. An asynchronous output enable gates the registered read word onto a bus model, which has a data port and a drive-enable flag.

Top module: `pbsram_top`

## Requirements
- R1: Every synchronous input is taken only at a rising clock edge. Each access uses the address, data and controls sampled on that edge.
- R2: An active-low controller strobe loads the sampled address. The cycle is selected only when the primary select is low, the second select is high and the third select is low.
- R3: An active-low processor strobe loads the address only when the primary select is low. With the primary select high it has no effect, and a burst in progress keeps its address.
- R4: On a continuation cycle (no strobe accepted) with advance low, the two low address bits step by one, wrapping from 3 to 0. The upper bits stay fixed.
- R5: On a continuation cycle with advance high, the same word is accessed again.
- R6: With byte-write master low and global write high, lane n is written where lane enable bit n is low. Lane 0 is data bits 8:0 and lane 1 is bits 17:9.
- R7: A low global write writes both lanes, whatever the lane enables and the master say.
- R8: With global write and byte-write master both high, the cycle is a read and the memory is left unchanged.
- R9: Read data is driven after the second rising edge after the address is sampled, and not after the first.
- R10: Output enable (active low) gates the bus with no clock edge. While it is high the drive flag is 0 and the bus value is 0.
- R11: A deselected cycle writes nothing and drives nothing on the following cycle.
- R12: After reset the device is deselected and the bus is not driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | 18 | Write data |
| sel1_n_i | input | 1 | Primary chip select, active low |
| sel2_i | input | 1 | Second chip select, active high |
| sel3_n_i | input | 1 | Third chip select, active low |
| pstrb_n_i | input | 1 | Processor-side address strobe, active low |
| cstrb_n_i | input | 1 | Controller-side address strobe, active low |
| adv_n_i | input | 1 | Burst advance, active low |
| bwen_n_i | input | 1 | Byte-write master enable, active low |
| lane_n_i | input | 2 | Per-lane write enables, active low |
| gwr_n_i | input | 1 | Global write, active low |
| oe_n_i | input | 1 | Asynchronous output enable, active low |
| bus_o | output | 18 | Read data on the bus model, 0 when not driven |
| bus_en_o | output | 1 | Bus drive flag |

## Verification
On every cycle, the assertions check how the burst address may move: the upper bits stay fixed during a burst, the low bits step with wrap or hold, and a processor strobe given while the primary select is high is ignored. They also check that a global write produces a full lane mask, that a cycle with no write controls is a read, and that a deselected cycle leaves the bus quiet. Only the bench scenarios can show that the correct words come back: the lane merges, the wrap order for each starting offset, the exact read latency, and the asynchronous output-enable gating between clock edges.

// File: rtl/pbsram_pkg.sv
package pbsram_pkg;
    localparam int WORD_W = 18;
    localparam int LANES  = 2;
    localparam int LANE_W = WORD_W / LANES;
    localparam int CNT_W  = 2;

    typedef struct packed {
        logic             ps_n;
        logic             cs_n;
        logic             ce1_n;
        logic             ce2;
        logic             ce3_n;
        logic             adv_n;
        logic             bw_n;
        logic             gw_n;
        logic [LANES-1:0] lane_n;
    } ctl_t;
endpackage

// File: rtl/pbsram_addr_gen.sv
module pbsram_addr_gen
    import pbsram_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ps_n,
    input  logic              cs_n,
    input  logic              ce1_n,
    input  logic              ce2,
    input  logic              ce3_n,
    input  logic              adv_n,
    input  logic [ADDR_W-1:0] addr,
    output logic [ADDR_W-1:0] acc_addr,
    output logic              acc_active
);
    localparam int UP_W = ADDR_W - CNT_W;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              act;
    } st_t;

    st_t  st_d, st_q;
    logic load;
    logic sel_now;

    always_comb begin
        load    = (!ps_n && !ce1_n) || !cs_n;
        sel_now = !ce1_n && ce2 && !ce3_n;
        st_d    = st_q;
        if (load) begin
            st_d.addr = addr;
            st_d.act  = sel_now;
        end else begin
            st_d.addr = {st_q.addr[ADDR_W-1:CNT_W],
                         st_q.addr[CNT_W-1:0] + CNT_W'(!adv_n)};
        end
        acc_addr   = st_d.addr;
        acc_active = st_d.act;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_BURST_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.act && !load) |=> $stable(st_q.addr[ADDR_W-1:CNT_W]));  // R4
    AST_WRAP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.act && !load && !adv_n) |=>
        (st_q.addr[CNT_W-1:0] == $past(st_q.addr[CNT_W-1:0]) + CNT_W'(1)));  // R4
    AST_HOLD_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.act && !load && adv_n) |=> $stable(st_q.addr));  // R5
    AST_PSTRB_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!ps_n && ce1_n && cs_n) |=> $stable(st_q.act));  // R3

    logic [UP_W-1:0] unused_up;
    assign unused_up = acc_addr[ADDR_W-1:CNT_W];
endmodule

// File: rtl/pbsram_wr_decode.sv
module pbsram_wr_decode
    import pbsram_pkg::*;
(
    input  logic             active,
    input  logic             gw_n,
    input  logic             bw_n,
    input  logic [LANES-1:0] lane_n,
    output logic [LANES-1:0] lane_we
);
    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            lane_we[i] = active && (!gw_n || (!bw_n && !lane_n[i]));
        end
    end
endmodule

// File: rtl/pbsram_array.sv
module pbsram_array
    import pbsram_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_active,
    input  logic [LANES-1:0]  lane_we,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_valid
);
    localparam int DEPTH = 1 << ADDR_W;

    typedef struct packed {
        logic [WORD_W-1:0] data;
        logic              valid;
    } out_t;

    out_t              out_d, out_q;
    logic [WORD_W-1:0] rd_word;
    logic              do_read;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem_l [DEPTH];
        always_ff @(posedge clk) begin
            if (lane_we[g]) begin
                mem_l[acc_addr] <= wdata[g*LANE_W +: LANE_W];
            end
        end
        assign rd_word[g*LANE_W +: LANE_W] = mem_l[acc_addr];
    end

    always_comb begin
        do_read     = acc_active && (lane_we == '0);
        out_d       = out_q;
        out_d.valid = do_read;
        if (do_read) begin
            out_d.data = rd_word;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign rd_data  = out_q.data;
    assign rd_valid = out_q.valid;
endmodule

// File: rtl/pbsram_top.sv
module pbsram_top
    import pbsram_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [ADDR_W-1:0]            addr_i,
    input  logic [pbsram_pkg::WORD_W-1:0] wdata_i,
    input  logic                         sel1_n_i,
    input  logic                         sel2_i,
    input  logic                         sel3_n_i,
    input  logic                         pstrb_n_i,
    input  logic                         cstrb_n_i,
    input  logic                         adv_n_i,
    input  logic                         bwen_n_i,
    input  logic [pbsram_pkg::LANES-1:0] lane_n_i,
    input  logic                         gwr_n_i,
    input  logic                         oe_n_i,
    output logic [pbsram_pkg::WORD_W-1:0] bus_o,
    output logic                         bus_en_o
);
    typedef struct packed {
        ctl_t              ctl;
        logic [ADDR_W-1:0] addr;
        logic [WORD_W-1:0] data;
    } in_t;

    in_t               in_d, in_q;
    logic [ADDR_W-1:0] acc_addr;
    logic              acc_active;
    logic [LANES-1:0]  lane_we;
    logic [WORD_W-1:0] rd_data;
    logic              rd_valid;

    always_comb begin
        in_d.ctl.ps_n   = pstrb_n_i;
        in_d.ctl.cs_n   = cstrb_n_i;
        in_d.ctl.ce1_n  = sel1_n_i;
        in_d.ctl.ce2    = sel2_i;
        in_d.ctl.ce3_n  = sel3_n_i;
        in_d.ctl.adv_n  = adv_n_i;
        in_d.ctl.bw_n   = bwen_n_i;
        in_d.ctl.gw_n   = gwr_n_i;
        in_d.ctl.lane_n = lane_n_i;
        in_d.addr       = addr_i;
        in_d.data       = wdata_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_q            <= '0;
            in_q.ctl.ps_n   <= 1'b1;
            in_q.ctl.cs_n   <= 1'b1;
            in_q.ctl.ce1_n  <= 1'b1;
            in_q.ctl.ce3_n  <= 1'b1;
            in_q.ctl.adv_n  <= 1'b1;
            in_q.ctl.bw_n   <= 1'b1;
            in_q.ctl.gw_n   <= 1'b1;
            in_q.ctl.lane_n <= '1;
        end else begin
            in_q <= in_d;
        end
    end

    pbsram_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .ps_n       (in_q.ctl.ps_n),
        .cs_n       (in_q.ctl.cs_n),
        .ce1_n      (in_q.ctl.ce1_n),
        .ce2        (in_q.ctl.ce2),
        .ce3_n      (in_q.ctl.ce3_n),
        .adv_n      (in_q.ctl.adv_n),
        .addr       (in_q.addr),
        .acc_addr   (acc_addr),
        .acc_active (acc_active)
    );

    pbsram_wr_decode u_dec (
        .active  (acc_active),
        .gw_n    (in_q.ctl.gw_n),
        .bw_n    (in_q.ctl.bw_n),
        .lane_n  (in_q.ctl.lane_n),
        .lane_we (lane_we)
    );

    pbsram_array #(.ADDR_W(ADDR_W)) u_arr (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_addr   (acc_addr),
        .acc_active (acc_active),
        .lane_we    (lane_we),
        .wdata      (in_q.data),
        .rd_data    (rd_data),
        .rd_valid   (rd_valid)
    );

    always_comb begin
        bus_en_o = rd_valid && !oe_n_i;
        bus_o    = bus_en_o ? rd_data : '0;
    end

    AST_GW_ALL_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_active && !in_q.ctl.gw_n) |-> (lane_we == '1));  // R7
    AST_NO_CTRL_READS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_q.ctl.gw_n && in_q.ctl.bw_n) |-> (lane_we == '0));  // R8
    AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_active) |=> !bus_en_o);  // R11
endmodule

// File: tb/pbsram_top_tb.sv
module pbsram_top_tb;
    localparam int AW = 6;
    localparam int N  = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] addr;
    logic [17:0]   wdata;
    logic          sel1_n, sel2, sel3_n, pstrb_n, cstrb_n, adv_n, bwen_n, gwr_n, oe_n;
    logic [1:0]    lane_n;
    logic [17:0]   bus;
    logic          bus_en;

    int errs   = 0;
    int checks = 0;
    logic [17:0] model [N];

    always #10 clk = ~clk;

    pbsram_top #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .addr_i(addr), .wdata_i(wdata),
        .sel1_n_i(sel1_n), .sel2_i(sel2), .sel3_n_i(sel3_n),
        .pstrb_n_i(pstrb_n), .cstrb_n_i(cstrb_n), .adv_n_i(adv_n),
        .bwen_n_i(bwen_n), .lane_n_i(lane_n), .gwr_n_i(gwr_n), .oe_n_i(oe_n),
        .bus_o(bus), .bus_en_o(bus_en)
    );

    function automatic logic [17:0] pat(input int a);
        return 18'(a * 2731 + 77);
    endfunction

    task automatic chk(input string req, input logic [17:0] got, input logic [17:0] exp);
        checks++;
        if (got !== exp) begin
            errs++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic drv_base();
        pstrb_n = 1; cstrb_n = 1; sel1_n = 0; sel2 = 1; sel3_n = 0;
        adv_n = 1; bwen_n = 1; gwr_n = 1; lane_n = 2'b11; addr = '0; wdata = '0;
    endtask

    task automatic drv_idle();
        drv_base(); cstrb_n = 0; sel1_n = 1;
    endtask

    task automatic drv_rd(input int a);
        drv_base(); cstrb_n = 0; addr = AW'(a);
    endtask

    task automatic drv_wr(input int a, input logic [17:0] d, input logic bw,
                          input logic gw, input logic [1:0] ln);
        drv_base(); cstrb_n = 0; addr = AW'(a); wdata = d;
        bwen_n = bw; gwr_n = gw; lane_n = ln;
    endtask

    task automatic drv_cont(input logic adv);
        drv_base(); adv_n = adv;
    endtask

    task automatic rd_chk(input int a, input string req);
        drv_rd(a); tick(); drv_idle(); tick();
        chk(req, {17'd0, bus_en}, 18'd1);
        chk(req, bus, model[a]);
    endtask

    initial begin
        #(20 * 200000);
        errs++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        rst_n = 0; oe_n = 0; drv_idle();
        repeat (3) tick();
        chk("R12 reset drive flag", {17'd0, bus_en}, 18'd0);
        chk("R12 reset bus", bus, 18'd0);
        rst_n = 1;
        tick();
        chk("R12 idle after reset", {17'd0, bus_en}, 18'd0);

        // fill with global writes
        for (int a = 0; a < N; a++) begin
            drv_wr(a, pat(a), 1'b1, 1'b0, 2'b11); tick();
            model[a] = pat(a);
        end
        drv_idle(); tick();
        chk("R7 write cycle leaves bus idle", {17'd0, bus_en}, 18'd0);

        // pipelined read sweep, R1 R2 R9
        drv_rd(0); tick();
        for (int a = 1; a < N; a++) begin
            drv_rd(a); tick();
            chk("R2 sweep read", bus, model[a-1]);
        end
        drv_idle(); tick();
        chk("R1 last sweep read", bus, model[N-1]);
        tick();
        chk("R11 deselect after sweep", {17'd0, bus_en}, 18'd0);

        // latency, R9
        drv_rd(5); tick();
        chk("R9 not after first edge", {17'd0, bus_en}, 18'd0);
        drv_idle(); tick();
        chk("R9 valid after second edge", {17'd0, bus_en}, 18'd1);
        chk("R9 data after second edge", bus, model[5]);

        // byte lanes, R6
        for (int m = 0; m < 4; m++) begin
            logic [17:0] d;
            d = 18'h2AAAA ^ 18'(m * 4099);
            drv_wr(10 + m, d, 1'b0, 1'b1, 2'(m)); tick();
            if (!m[0]) model[10+m][8:0]  = d[8:0];
            if (!m[1]) model[10+m][17:9] = d[17:9];
            drv_idle(); tick();
            rd_chk(10 + m, "R6 lane merge");
        end
        // R8: lane enables without master or global is a read
        drv_wr(14, 18'h15555, 1'b1, 1'b1, 2'b00); tick();
        drv_idle(); tick();
        chk("R8 no-write cycle reads", bus, model[14]);
        rd_chk(14, "R8 memory unchanged");
        // R7: global overrides
        drv_wr(15, 18'h3C3C3, 1'b1, 1'b0, 2'b11); tick();
        model[15] = 18'h3C3C3;
        drv_idle(); tick();
        rd_chk(15, "R7 global write");

        // bursts with wrap, R4
        for (int s = 0; s < 4; s++) begin
            drv_rd(32 + s); tick();
            for (int k = 0; k < 4; k++) begin
                if (k < 3) drv_cont(1'b0); else drv_idle();
                tick();
                chk("R4 burst order", bus, model[32 + ((s + k) & 3)]);
            end
            tick();
        end

        // hold with advance high, R5
        drv_rd(21); tick();
        drv_cont(1'b1); tick();
        chk("R5 hold first", bus, model[21]);
        drv_cont(1'b1); tick();
        chk("R5 hold second", bus, model[21]);
        drv_idle(); tick();
        chk("R5 hold third", bus, model[21]);
        tick();

        // processor strobe, R3
        drv_base(); pstrb_n = 0; addr = AW'(40); tick();
        drv_base(); pstrb_n = 0; sel1_n = 1; addr = AW'(41); tick();
        chk("R3 processor strobe load", bus, model[40]);
        drv_idle(); tick();
        chk("R3 ignored strobe keeps word", bus, model[40]);
        tick();
        chk("R3 controller strobe deselects", {17'd0, bus_en}, 18'd0);

        // deselected writes, R11
        drv_wr(3, 18'h0F0F0, 1'b1, 1'b0, 2'b11); sel2 = 0; tick();
        drv_wr(4, 18'h0F0F0, 1'b1, 1'b0, 2'b11); sel3_n = 1; tick();
        chk("R11 no drive after deselect", {17'd0, bus_en}, 18'd0);
        drv_idle(); tick();
        chk("R11 no drive second", {17'd0, bus_en}, 18'd0);
        rd_chk(3, "R11 write ignored sel2");
        rd_chk(4, "R11 write ignored sel3");

        // asynchronous output enable, R10
        drv_rd(7); tick(); drv_idle(); tick();
        oe_n = 1; #3;
        chk("R10 flag off", {17'd0, bus_en}, 18'd0);
        chk("R10 bus zero", bus, 18'd0);
        oe_n = 0; #3;
        chk("R10 flag back", {17'd0, bus_en}, 18'd1);
        chk("R10 data back", bus, model[7]);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule